// File: doc/BRIEF.md
# Single-Register Interrupt Aggregator

This block gathers a small group of level-type interrupt sources into one summary interrupt line for a parent controller. Software controls and observes it through a single 32-bit word: the low half carries one enable bit per source and the high half carries one latched status bit per source. Each status bit sits exactly 16 positions above the enable bit of the same source.

A source that is high on a clock edge sets its status bit. The status bit stays set until software writes a 1 to it. A status bit records events even when its enable is off, but only bits whose enable is on drive the summary output. Parameters choose how many sources exist and at which bit the first one sits. All other bits of the word read as zero and ignore writes.

A register access takes one cycle and is never stalled, so the port has select and write-enable but no back-pressure. Every write loads the enable field from the write data. A read-modify-write of the enables must therefore put zeros in the status field, or it clears pending events.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every enable bit, every status bit and `irq_out` are 0.
- R2: A write (`reg_sel` and `reg_we` both high) loads enable bit of source i, at register bit FIRST_BIT+i, from the same bit of `reg_wdata` on that clock edge.
- R3: A write with a 1 at register bit FIRST_BIT+i+16 clears status bit i on that edge when source i is low; a 0 in that position leaves the status bit unchanged.
- R4: A source input that is high at a clock edge sets its status bit on that edge, whether or not its enable is set.
- R5: Register bits outside the implemented enable range and the matching status range read as 0, and writes to them have no effect.
- R6: `irq_out` is high one cycle after any status bit is set together with its enable bit, and low one cycle after no such pair remains.
- R7: When a clear and a high source level meet in the same cycle, the set wins and the status bit stays 1. A source that is still high after a clear therefore raises its bit again.
- R8: While `reg_sel` is high, `reg_rdata` shows the current {status, enable} word in the same cycle. While `reg_sel` is low it reads 0, and `reg_we` alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select for read and write |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 32 | Write data: enables low half, clear-by-one status high half |
| reg_rdata | output | 32 | Read data: {status, enable}, zero when not selected |
| src_in | input | NUM_SRC | Raw level interrupt sources |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
The hardest case to reach is a clear write that lands on the same edge as a high source level. The bench holds one source high across a write that has a 1 in that source's status position, then reads the bit back. Disabling an enable while its status stays pending is also hard to reach. The bench sets a status bit, enables it, then writes zero enables with a zero status field, and follows `irq_out` edge by edge as it falls. The bench sets the first source at bit 4 so that bits below and above the implemented field are probed as well.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = 16;

  // Mask covering cnt bits starting at position first.
  function automatic logic [REG_W-1:0] field_mask(input int first, input int cnt);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < REG_W; k++) begin
      if (k >= first && k < first + cnt) m[k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_agg_enable_reg.sv
module irq_agg_enable_reg #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_bits,
  output logic [NUM_SRC-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_bits;
  end

  // R2: a write loads the field verbatim
  p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en_q == $past(wr_bits));
  // R2: no write keeps the field
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] st_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic clr;
    assign clr = wr_en & clr_bits[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         st_q[g] <= 1'b0;
      else if (src_in[g]) st_q[g] <= 1'b1;
      else if (clr)       st_q[g] <= 1'b0;
    end

    // R4 / R7: a high source always leaves the bit set
    p_src_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      src_in[g] |=> st_q[g]);
    // R3: clear with a quiet source empties the bit
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !src_in[g]) |=> !st_q[g]);
    // R3: no clear keeps a pending bit
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] && !clr) |=> st_q[g]);
  end
endmodule

// File: rtl/irq_agg_summary.sv
module irq_agg_summary #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] st,
  input  logic [NUM_SRC-1:0] en,
  output logic               irq_q
);
  logic any_pending;
  assign any_pending = |(st & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pending;
  end

  // R6: rise one cycle after an enabled pending bit
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st & en)) |=> irq_q);
  // R6: fall one cycle after none remains
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st & en)) |=> !irq_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC   = 7,
  parameter int FIRST_BIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out
);
  localparam int ST_BIT = FIRST_BIT + HALF_W;
  localparam logic [REG_W-1:0] IMPL_ALL =
    field_mask(FIRST_BIT, NUM_SRC) | field_mask(ST_BIT, NUM_SRC);

  logic               wr_en;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] st_q;
  logic [REG_W-1:0]   word;
  logic               unused_wbits;

  assign wr_en        = reg_sel & reg_we;
  assign unused_wbits = ^(reg_wdata & ~IMPL_ALL);

  irq_agg_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_bits(reg_wdata[FIRST_BIT +: NUM_SRC]),
    .en_q   (en_q)
  );

  irq_agg_status #(.NUM_SRC(NUM_SRC)) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .clr_bits(reg_wdata[ST_BIT +: NUM_SRC]),
    .src_in  (src_in),
    .st_q    (st_q)
  );

  irq_agg_summary #(.NUM_SRC(NUM_SRC)) u_sum (
    .clk  (clk),
    .rst_n(rst_n),
    .st   (st_q),
    .en   (en_q),
    .irq_q(irq_out)
  );

  always_comb begin
    word = '0;
    word[FIRST_BIT +: NUM_SRC] = en_q;
    word[ST_BIT +: NUM_SRC]    = st_q;
  end

  assign reg_rdata = reg_sel ? word : '0;

  // R5: unimplemented bits never read as 1
  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL_ALL) == '0);
  // R8: idle port reads zero
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata == '0);
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NS = 6;
  localparam int FB = 4;
  localparam logic [31:0] EN_M = ((32'd1 << NS) - 1) << FB;
  localparam logic [31:0] ST_M = EN_M << 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_sel = 1'b0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NS-1:0] src_in = '0;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_aggregator #(.NUM_SRC(NS), .FIRST_BIT(FB)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_sel = 1'b1;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] s);
    @(negedge clk); src_in = s;
    @(negedge clk); src_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(d);
    chk("R1 reset word", d, 32'h0);
    chk("R1 reset irq", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(32'h0000_FFFF);
    rd(d);
    chk("R2/R5 enable all", d, EN_M);
    wr(32'h0000_0150);
    rd(d);
    chk("R2 enable pattern", d, 32'h0000_0150 & EN_M);
    wr(32'h0);
  endtask

  task automatic t_latch_disabled();
    logic [31:0] d;
    pulse(6'b000010);
    rd(d);
    chk("R4 latch with enable off", d, 32'h1 << (16 + FB + 1));
    @(negedge clk);
    chk("R6 no irq when disabled", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(32'h0000_0000);
    rd(d);
    chk("R3 zero write keeps status", d, 32'h1 << (16 + FB + 1));
    wr(32'h1 << (16 + FB + 1));
    rd(d);
    chk("R3 one write clears status", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(32'h1 << (FB + 2));
    @(negedge clk); src_in = 6'b000100;
    @(negedge clk); src_in = '0;
    chk("R6 irq not yet", {31'd0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R6 irq raised", {31'd0, irq_out}, 32'h1);
    wr(32'h0);
    chk("R6 irq lags disable", {31'd0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R6 irq low after disable", {31'd0, irq_out}, 32'h0);
    rd(d);
    chk("R3 enable-only write keeps pending", d, 32'h1 << (16 + FB + 2));
    wr(32'h1 << (FB + 2));
    @(negedge clk);
    chk("R6 irq on re-enable", {31'd0, irq_out}, 32'h1);
    wr((32'h1 << (16 + FB + 2)) | (32'h1 << (FB + 2)));
    @(negedge clk);
    chk("R6 irq low after clear", {31'd0, irq_out}, 32'h0);
    wr(32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    @(negedge clk); src_in = 6'b100000;
    wr(32'h1 << (16 + FB + 5));
    rd(d);
    chk("R7 set wins over clear", d, 32'h1 << (16 + FB + 5));
    src_in = '0;
    wr(32'h1 << (16 + FB + 5));
    rd(d);
    chk("R7 clear after source drops", d, 32'h0);
  endtask

  task automatic t_outside();
    logic [31:0] d;
    pulse(6'b111111);
    wr(~(EN_M | ST_M));
    rd(d);
    chk("R5 outside bits ignored", d, ST_M);
    wr(ST_M);
    rd(d);
    chk("R5 clear all implemented", d, 32'h0);
  endtask

  task automatic t_sel_low();
    logic [31:0] d;
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = 32'h0000_FFFF;
    #1 chk("R8 read zero unselected", reg_rdata, 32'h0);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    rd(d);
    chk("R8 write without select ignored", d, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_latch_disabled();
    t_w1c();
    t_irq();
    t_priority();
    t_outside();
    t_sel_low();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule